// File: doc/BRIEF.md
# Nested Hardware Loop Sequencer

This block gives a 16-bit DSP sequencer loops that cost no cycles at the loop end. It watches every completed instruction and recognises four loop-setup forms. Two forms repeat only the next instruction. The other two repeat a block of instructions whose last address is given in a second instruction word. Each form takes its trip count either from an 8-bit immediate or from a 16-bit register that it reads through a register-file port.

Loop state is kept on three hardware stacks that move together: one for the repeat address, one for the end address and one for the remaining count. After each completed instruction, the block compares the instruction's address with the end address on top of the stack. It then either sends the program counter back to the repeat address or retires the loop and falls through. A setup with a zero count pushes nothing and skips the loop body.

The next program counter is held in a register. It changes only on the instruction-complete strobe, so the rest of the sequencer can fetch from it directly.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, `next_pc` equals `RESET_PC`, `loop_depth` is 0 and `stack_fault` is 0.
- R2: An instruction that is not a loop setup, with no branch and no loop-end match, sets `next_pc` to `exec_pc + exec_len`. An empty count stack reads as zero, so no loop-end match can occur while the stacks are empty.
- R3: Setup encodings are fixed. `0x0040 | r` is a single-instruction register loop and `0x0060 | r` is a register block loop, where r is bits 4:0. `0x1000 | i` is a single-instruction immediate loop and `0x1100 | i` is an immediate block loop, where i is bits 7:0. For the register forms, `rf_sel` carries bits 4:0 of `instr_word` and the 16-bit count is taken from `rf_data`.
- R4: A setup with a nonzero count pushes one entry onto each stack, so `loop_depth` rises by 1. For a single loop, `next_pc` becomes `exec_pc + 1`, and both the repeat and end addresses equal that value. For a block loop, `next_pc` becomes `exec_pc + 2`, the repeat address is `exec_pc + 2` and the end address is `ext_word`, inclusive.
- R5: When the count on top of the stack is nonzero and `exec_pc` equals the top end address, the count is decremented. If the result is nonzero, `next_pc` becomes the top repeat address. A loop with count N therefore runs its body N times.
- R6: When that decrement reaches zero, all three stacks pop, `loop_depth` falls by 1 and `next_pc` becomes `exec_pc + exec_len`.
- R7: A single-loop setup with a zero count pushes nothing and skips the following instruction. `size_addr` carries `exec_pc + 1`, and `next_pc` becomes `exec_pc + 1 + size_words`.
- R8: A block-loop setup with a zero count pushes nothing. `size_addr` carries `ext_word`, and `next_pc` becomes `ext_word + size_words`.
- R9: Loops nest up to `MAX_NEST` deep. Only the innermost loop is checked, so an inner loop runs to completion each time round the outer loop.
- R10: A setup with a nonzero count while `MAX_NEST` loops are already active leaves all stacks and `loop_depth` unchanged. It sets `stack_fault`, which stays set until reset, and `next_pc` still advances past the setup instruction.
- R11: A taken branch on the completing instruction sets `next_pc` to `branch_target`. It takes priority over the loop-end check and leaves the count and `loop_depth` unchanged.
- R12: `next_pc` does not change in any cycle without `instr_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_done | input | 1 | Strobe: the instruction at `exec_pc` has completed |
| exec_pc | input | 16 | Address of the completed instruction |
| exec_len | input | 2 | Length of the completed instruction in words (1 or 2) |
| instr_word | input | 16 | First word of the completed instruction |
| ext_word | input | 16 | Second word of the completed instruction (block end address) |
| branch_taken | input | 1 | The completed instruction redirects the flow |
| branch_target | input | 16 | Destination of that redirect |
| rf_sel | output | 5 | Register index for the count read |
| rf_data | input | 16 | Register-file data for `rf_sel` |
| size_addr | output | 16 | Address whose instruction length is requested |
| size_words | input | 2 | Length in words of the instruction at `size_addr` |
| next_pc | output | 16 | Registered next program counter |
| loop_depth | output | $clog2(MAX_NEST+1) | Number of active loops |
| stack_fault | output | 1 | Sticky flag for a stack overflow or underflow |

## Verification
The bench builds the block with `MAX_NEST` = 4 and `RESET_PC` = 0. A depth of 4 lets five nested setups reach the overflow case, while a two-level nest still fits in a short directed run. Its instruction-size model gives two words only at address 0x0050, so a zero-count skip over a two-word last instruction is told apart from a skip over a one-word one. Branch priority is shown indirectly: after a branch taken at the loop end, the loop still needs its full remaining count of passes before it retires.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

  localparam int WORD_W = 16;
  localparam int RSEL_W = 5;
  localparam int IMM_W  = 8;

  typedef struct packed {
    logic              setup;
    logic              block;
    logic              use_reg;
    logic [RSEL_W-1:0] rsel;
    logic [IMM_W-1:0]  imm;
  } loop_op_t;

  // Recognise the four loop-setup encodings in a first instruction word.
  function automatic loop_op_t decode_op(input logic [WORD_W-1:0] w);
    loop_op_t op;
    op.rsel    = w[RSEL_W-1:0];
    op.imm     = w[IMM_W-1:0];
    op.setup   = 1'b0;
    op.block   = 1'b0;
    op.use_reg = 1'b0;
    if (w[15:6] == 10'b0000_0000_01) begin
      op.setup   = 1'b1;
      op.use_reg = 1'b1;
      op.block   = w[5];
    end else if (w[15:9] == 7'b0001_000) begin
      op.setup   = 1'b1;
      op.block   = w[8];
    end
    return op;
  endfunction

  // Address arithmetic: advance by a length in words, wrapping at 16 bits.
  function automatic logic [WORD_W-1:0] pc_add(input logic [WORD_W-1:0] pc,
                                               input logic [1:0]        n);
    return pc + {{(WORD_W-2){1'b0}}, n};
  endfunction

endpackage

// File: rtl/hwloop_decode.sv
module hwloop_decode
  import hwloop_pkg::*;
(
  input  logic [WORD_W-1:0] instr_word,
  input  logic [WORD_W-1:0] rf_data,
  output loop_op_t          op,
  output logic [RSEL_W-1:0] rf_sel,
  output logic [WORD_W-1:0] count,
  output logic              count_zero
);

  always_comb begin
    op         = decode_op(instr_word);
    rf_sel     = op.rsel;
    count      = op.use_reg ? rf_data : {{(WORD_W-IMM_W){1'b0}}, op.imm};
    count_zero = (count == '0);
  end

endmodule

// File: rtl/hw_stack.sv
module hw_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [W-1:0]               push_d,
  input  logic                       pop_i,
  input  logic                       set_i,
  input  logic [W-1:0]               set_d,
  output logic [W-1:0]               top_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       ovf_o,
  output logic                       unf_o
);

  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [AW-1:0] wr_idx, top_idx;
  logic          empty, full;

  assign empty   = (ptr == '0);
  assign full    = (ptr == PW'(DEPTH));
  assign wr_idx  = AW'(ptr);
  assign top_idx = AW'(ptr - PW'(1));
  assign top_o   = empty ? '0 : mem[top_idx];
  assign level_o = ptr;
  assign ovf_o   = push_i & full;
  assign unf_o   = (pop_i | set_i) & empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push_i && !full) begin
      mem[wr_idx] <= push_d;
      ptr         <= ptr + PW'(1);
    end else if (pop_i && !empty) begin
      ptr <= ptr - PW'(1);
    end else if (set_i && !empty) begin
      mem[top_idx] <= set_d;
    end
  end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int          MAX_NEST = 4,
  parameter logic [15:0] RESET_PC = 16'h0000,
  localparam int         LW       = $clog2(MAX_NEST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic [15:0]       exec_pc,
  input  logic [1:0]        exec_len,
  input  logic [15:0]       instr_word,
  input  logic [15:0]       ext_word,
  input  logic              branch_taken,
  input  logic [15:0]       branch_target,
  output logic [4:0]        rf_sel,
  input  logic [15:0]       rf_data,
  output logic [15:0]       size_addr,
  input  logic [1:0]        size_words,
  output logic [15:0]       next_pc,
  output logic [LW-1:0]     loop_depth,
  output logic              stack_fault
);

  localparam int NSTK  = 3;
  localparam int S_REP = 0;
  localparam int S_END = 1;
  localparam int S_CNT = 2;

  loop_op_t    op;
  logic [15:0] count;
  logic        count_zero;

  hwloop_decode u_dec (
    .instr_word (instr_word),
    .rf_data    (rf_data),
    .op         (op),
    .rf_sel     (rf_sel),
    .count      (count),
    .count_zero (count_zero)
  );

  // Stack wiring, one lane per stack.
  logic [15:0]   stk_push_d [NSTK];
  logic [15:0]   stk_top    [NSTK];
  logic [LW-1:0] stk_level  [NSTK];
  logic [NSTK-1:0] stk_set, stk_ovf, stk_unf;
  logic [15:0]   cnt_dec;

  // Named events, visible to the checker.
  logic        setup_ev, push_req, loop_hit, loop_chk, loop_back, loop_exit;
  logic [15:0] rep_addr, end_addr, skip_pc, rep_top, end_top, ctr_top;
  logic [15:0] pc_nxt;

  assign rep_top = stk_top[S_REP];
  assign end_top = stk_top[S_END];
  assign ctr_top = stk_top[S_CNT];

  assign rep_addr  = pc_add(exec_pc, op.block ? 2'd2 : 2'd1);
  assign end_addr  = op.block ? ext_word : pc_add(exec_pc, 2'd1);
  assign size_addr = end_addr;
  assign skip_pc   = pc_add(end_addr, size_words);

  assign setup_ev  = instr_done & ~branch_taken & op.setup;
  assign push_req  = setup_ev & ~count_zero;
  assign loop_hit  = (ctr_top != '0) && (exec_pc == end_top);
  assign loop_chk  = instr_done & ~branch_taken & ~op.setup & loop_hit;
  assign cnt_dec   = ctr_top - 16'd1;
  assign loop_back = loop_chk & (cnt_dec != '0);
  assign loop_exit = loop_chk & (cnt_dec == '0);

  assign stk_push_d[S_REP] = rep_addr;
  assign stk_push_d[S_END] = end_addr;
  assign stk_push_d[S_CNT] = count;

  for (genvar g = 0; g < NSTK; g++) begin : g_stk
    assign stk_set[g] = (g == S_CNT) ? loop_back : 1'b0;
    hw_stack #(.W(16), .DEPTH(MAX_NEST)) u_stk (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push_req),
      .push_d  (stk_push_d[g]),
      .pop_i   (loop_exit),
      .set_i   (stk_set[g]),
      .set_d   (cnt_dec),
      .top_o   (stk_top[g]),
      .level_o (stk_level[g]),
      .ovf_o   (stk_ovf[g]),
      .unf_o   (stk_unf[g])
    );
  end

  assign loop_depth = stk_level[S_CNT];

  // Priority: branch, then setup, then loop-end check, then sequential.
  always_comb begin
    if (branch_taken)     pc_nxt = branch_target;
    else if (op.setup)    pc_nxt = count_zero ? skip_pc : rep_addr;
    else if (loop_back)   pc_nxt = rep_top;
    else                  pc_nxt = pc_add(exec_pc, exec_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc     <= RESET_PC;
      stack_fault <= 1'b0;
    end else begin
      if (instr_done) next_pc <= pc_nxt;
      if ((|stk_ovf) || (|stk_unf)) stack_fault <= 1'b1;
    end
  end

endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
  parameter int MAX_NEST = 4,
  parameter int LW       = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_done,
  input logic          branch_taken,
  input logic [15:0]   branch_target,
  input logic [15:0]   next_pc,
  input logic [LW-1:0] loop_depth,
  input logic          stack_fault,
  input logic          loop_back,
  input logic          loop_exit,
  input logic          push_req,
  input logic [15:0]   rep_top
);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |=> $stable(next_pc));

  // R11
  branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && branch_taken) |=> next_pc == $past(branch_target));

  // R11
  branch_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && branch_taken) |=> $stable(loop_depth));

  // R5
  loop_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_back |=> next_pc == $past(rep_top));

  // R6
  exit_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_exit |=> loop_depth == $past(loop_depth) - LW'(1));

  // R4
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && loop_depth < LW'(MAX_NEST)) |=> loop_depth == $past(loop_depth) + LW'(1));

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_fault |=> stack_fault);

  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_depth <= LW'(MAX_NEST));

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.MAX_NEST(MAX_NEST), .LW(LW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_done    (instr_done),
  .branch_taken  (branch_taken),
  .branch_target (branch_target),
  .next_pc       (next_pc),
  .loop_depth    (loop_depth),
  .stack_fault   (stack_fault),
  .loop_back     (loop_back),
  .loop_exit     (loop_exit),
  .push_req      (push_req),
  .rep_top       (rep_top)
);

// File: tb/tb_hwloop_ctrl.sv
module tb_hwloop_ctrl;

  localparam int CLK_P = 10;
  localparam int NEST  = 4;
  localparam int LW    = $clog2(NEST + 1);
  localparam logic [15:0] NOP = 16'h8000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instr_done = 1'b0;
  logic [15:0]   exec_pc = '0;
  logic [1:0]    exec_len = 2'd1;
  logic [15:0]   instr_word = NOP;
  logic [15:0]   ext_word = '0;
  logic          branch_taken = 1'b0;
  logic [15:0]   branch_target = '0;
  logic [4:0]    rf_sel;
  logic [15:0]   rf_data;
  logic [15:0]   size_addr;
  logic [1:0]    size_words;
  logic [15:0]   next_pc;
  logic [LW-1:0] loop_depth;
  logic          stack_fault;

  logic [15:0] regs [32];
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  // Bench register file and instruction-length model.
  always_comb rf_data = regs[rf_sel];
  always_comb size_words = (size_addr == 16'h0050) ? 2'd2 : 2'd1;

  hwloop_ctrl #(.MAX_NEST(NEST), .RESET_PC(16'h0000)) dut (
    .clk (clk), .rst_n (rst_n), .instr_done (instr_done),
    .exec_pc (exec_pc), .exec_len (exec_len), .instr_word (instr_word),
    .ext_word (ext_word), .branch_taken (branch_taken),
    .branch_target (branch_target), .rf_sel (rf_sel), .rf_data (rf_data),
    .size_addr (size_addr), .size_words (size_words), .next_pc (next_pc),
    .loop_depth (loop_depth), .stack_fault (stack_fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    instr_done = 1'b0;
    branch_taken = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One completed instruction; returns after next_pc has been updated.
  task automatic step(input logic [15:0] pc, input logic [15:0] w,
                      input logic [15:0] ext, input logic [1:0] len,
                      input logic br, input logic [15:0] tgt);
    @(negedge clk);
    exec_pc = pc; instr_word = w; ext_word = ext; exec_len = len;
    branch_taken = br; branch_target = tgt; instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0; branch_taken = 1'b0; instr_word = NOP;
  endtask

  task automatic nop_at(input logic [15:0] pc);
    step(pc, NOP, 16'h0, 2'd1, 1'b0, 16'h0);
  endtask

  task automatic t_reset();
    chk("R1 next_pc", int'(next_pc), 0);
    chk("R1 depth", int'(loop_depth), 0);
    chk("R1 fault", int'(stack_fault), 0);
  endtask

  task automatic t_sequential();
    nop_at(16'h0000);
    chk("R2 empty stack no match", int'(next_pc), 16'h0001);
    step(16'h0010, NOP, 16'h0, 2'd2, 1'b0, 16'h0);
    chk("R2 two-word advance", int'(next_pc), 16'h0012);
    chk("R2 depth", int'(loop_depth), 0);
  endtask

  task automatic t_single_imm();
    step(16'h0020, 16'h1003, 16'h0, 2'd1, 1'b0, 16'h0);
    chk("R4 single imm next", int'(next_pc), 16'h0021);
    chk("R4 depth", int'(loop_depth), 1);
    nop_at(16'h0021);
    chk("R5 pass1", int'(next_pc), 16'h0021);
    nop_at(16'h0021);
    chk("R5 pass2", int'(next_pc), 16'h0021);
    nop_at(16'h0021);
    chk("R6 exit next", int'(next_pc), 16'h0022);
    chk("R6 depth", int'(loop_depth), 0);
  endtask

  task automatic t_single_reg();
    regs[5] = 16'd2;
    @(negedge clk);
    instr_word = 16'h0045;
    #1;
    chk("R3 rf_sel", int'(rf_sel), 5);
    step(16'h0030, 16'h0045, 16'h0, 2'd1, 1'b0, 16'h0);
    chk("R3 reg loop next", int'(next_pc), 16'h0031);
    chk("R3 depth", int'(loop_depth), 1);
    nop_at(16'h0031);
    chk("R5 reg pass1", int'(next_pc), 16'h0031);
    nop_at(16'h0031);
    chk("R6 reg exit", int'(next_pc), 16'h0032);
  endtask

  task automatic t_block_imm();
    step(16'h0040, 16'h1102, 16'h0044, 2'd2, 1'b0, 16'h0);
    chk("R4 block next", int'(next_pc), 16'h0042);
    for (int pass = 0; pass < 2; pass++) begin
      nop_at(16'h0042);
      chk("R5 block body", int'(next_pc), 16'h0043);
      nop_at(16'h0043);
      nop_at(16'h0044);
      if (pass == 0) chk("R5 block back", int'(next_pc), 16'h0042);
      else           chk("R6 block exit", int'(next_pc), 16'h0045);
    end
    chk("R6 block depth", int'(loop_depth), 0);
  endtask

  task automatic t_zero_counts();
    regs[7] = 16'd0;
    step(16'h0060, 16'h0067, 16'h0050, 2'd2, 1'b0, 16'h0);
    chk("R8 reg block zero skip", int'(next_pc), 16'h0052);
    chk("R8 no push", int'(loop_depth), 0);
    step(16'h0060, 16'h1100, 16'h0050, 2'd2, 1'b0, 16'h0);
    chk("R8 imm block zero skip", int'(next_pc), 16'h0052);
    step(16'h0060, 16'h1000, 16'h0, 2'd1, 1'b0, 16'h0);
    chk("R7 imm single zero skip", int'(next_pc), 16'h0062);
    regs[3] = 16'd0;
    step(16'h004F, 16'h0043, 16'h0, 2'd1, 1'b0, 16'h0);
    chk("R7 reg single zero two-word", int'(next_pc), 16'h0052);
    chk("R7 no push", int'(loop_depth), 0);
  endtask

  task automatic t_nested();
    step(16'h0070, 16'h1102, 16'h0074, 2'd2, 1'b0, 16'h0);
    for (int outer = 0; outer < 2; outer++) begin
      step(16'h0072, 16'h1002, 16'h0, 2'd1, 1'b0, 16'h0);
      chk("R9 inner setup depth", int'(loop_depth), 2);
      nop_at(16'h0073);
      chk("R9 inner back", int'(next_pc), 16'h0073);
      nop_at(16'h0073);
      chk("R9 inner exit", int'(next_pc), 16'h0074);
      nop_at(16'h0074);
      if (outer == 0) chk("R9 outer back", int'(next_pc), 16'h0072);
      else            chk("R9 outer exit", int'(next_pc), 16'h0075);
    end
    chk("R9 final depth", int'(loop_depth), 0);
  endtask

  task automatic t_overflow();
    for (int k = 0; k < NEST; k++)
      step(16'h0080 + 16'(k), 16'h1005, 16'h0, 2'd1, 1'b0, 16'h0);
    chk("R10 full depth", int'(loop_depth), NEST);
    chk("R10 no fault yet", int'(stack_fault), 0);
    step(16'h0084, 16'h1005, 16'h0, 2'd1, 1'b0, 16'h0);
    chk("R10 depth held", int'(loop_depth), NEST);
    chk("R10 fault set", int'(stack_fault), 1);
    chk("R10 next past setup", int'(next_pc), 16'h0085);
    nop_at(16'h0090);
    chk("R10 fault sticky", int'(stack_fault), 1);
  endtask

  task automatic t_branch();
    step(16'h00A0, 16'h1003, 16'h0, 2'd1, 1'b0, 16'h0);
    step(16'h00A1, NOP, 16'h0, 2'd1, 1'b1, 16'h0200);
    chk("R11 branch target", int'(next_pc), 16'h0200);
    chk("R11 depth kept", int'(loop_depth), 1);
    nop_at(16'h00A1);
    chk("R11 count untouched 1", int'(next_pc), 16'h00A1);
    nop_at(16'h00A1);
    chk("R11 count untouched 2", int'(next_pc), 16'h00A1);
    nop_at(16'h00A1);
    chk("R11 exit after full count", int'(next_pc), 16'h00A2);
  endtask

  task automatic t_hold();
    nop_at(16'h0123);
    repeat (5) @(negedge clk);
    chk("R12 held", int'(next_pc), 16'h0124);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 16'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_sequential();
    t_single_imm();
    t_single_reg();
    t_block_imm();
    t_zero_counts();
    t_nested();
    t_overflow();
    do_reset();
    #1;
    t_reset();
    t_branch();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule